// File: doc/BRIEF.md
# Zero-Wait Fixed-Window Instruction Memory

This block stands in place of an instruction cache when all hot code must run without wait states and no address translation is in use. It holds a word-wide on-chip memory mapped at a fixed, size-aligned window of the fetch address space. There is no tag storage. An address's upper bits alone decide where a fetch goes: inside the window it always hits, and outside it never does.

A fetch that hits reads the memory and answers on the next cycle. A fetch that misses is passed to a bus request port. The core waits until the bus acknowledges, and the bus data is handed back to the core unchanged. The memory is filled through a word-wide preload write port, typically before the core starts fetching. The memory size is a parameter and reaches at least 512 KB.

Top module: `fixed_window_iram`

## Requirements
- R1: While reset is held and right after it, `core_ready` and `bus_req` are both low.
- R2: A fetch accepted at an address in the window [WIN_BASE, WIN_BASE+MEM_BYTES) gets `core_ready` high on the next cycle. That cycle `core_rdata` carries the word last preloaded at word index (address − WIN_BASE)/4.
- R3: In-window fetches may be issued every cycle, and each gets its own data one cycle later in issue order.
- R4: A fetch accepted outside the window raises `bus_req` on the next cycle, with `bus_addr` equal to the fetch address. Both hold steady until `bus_ack` is seen.
- R5: An in-window fetch never raises `bus_req`.
- R6: In the cycle `bus_ack` is high during a pending bus access, `core_ready` is high and `core_rdata` equals `bus_rdata`. `bus_req` is low on the following cycle.
- R7: `core_ready` stays low while a bus access waits for its acknowledge.
- R8: Fetch requests presented while a bus access is pending, including its acknowledge cycle, are ignored and produce no response.
- R9: A preload write made while `core_req` is high is discarded, and the stored word keeps its old value.
- R10: The first and last words of the window hit. The word just below the base and the word at base+MEM_BYTES miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Fetch request from the core |
| core_addr | input | 32 | Fetch byte address (word aligned) |
| core_rdata | output | 32 | Instruction word returned to the core |
| core_ready | output | 1 | Returned word is valid this cycle |
| bus_req | output | 1 | Out-of-window fetch pending on the bus |
| bus_addr | output | 32 | Address of the pending bus fetch |
| bus_rdata | input | 32 | Bus read data |
| bus_ack | input | 1 | Bus read data valid |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | log2(MEM_BYTES/4) | Preload word index |
| pl_wdata | input | 32 | Preload word |

## Verification
Two functions can fall in the same cycle. A preload write can meet a core fetch of the very word it targets, and a new fetch can arrive while a bus access is still waiting or being acknowledged. The bench pairs a preload with an in-window fetch of the same index. It expects the read to return the old word and expects a later read to show that the write was dropped. During random bus waits it keeps pushing in-window fetches. It judges them by the absence of any `core_ready` pulse after the acknowledge.

// File: rtl/fixed_window_iram.sv
module fixed_window_iram #(
  parameter int unsigned MEM_BYTES = 4096,
  parameter logic [31:0] WIN_BASE  = 32'h0000_4000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              core_req,
  input  logic [31:0]                       core_addr,
  output logic [31:0]                       core_rdata,
  output logic                              core_ready,
  output logic                              bus_req,
  output logic [31:0]                       bus_addr,
  input  logic [31:0]                       bus_rdata,
  input  logic                              bus_ack,
  input  logic                              pl_we,
  input  logic [$clog2(MEM_BYTES/4)-1:0]    pl_addr,
  input  logic [31:0]                       pl_wdata
);
  localparam int unsigned WORDS = MEM_BYTES / 4;
  localparam int unsigned OFF_W = $clog2(MEM_BYTES);

  logic [31:0] mem [WORDS];
  logic [31:0] rd_q;
  logic        hit_v;
  logic        pend;
  logic [31:0] pend_addr;

  logic in_win, take_hit, take_miss, unused_lo;
  assign in_win    = core_addr[31:OFF_W] == WIN_BASE[31:OFF_W];
  assign take_hit  = core_req & ~pend & in_win;
  assign take_miss = core_req & ~pend & ~in_win;
  assign unused_lo = ^core_addr[1:0];

  always_ff @(posedge clk) begin
    if (pl_we && !core_req) mem[pl_addr] <= pl_wdata;
    if (take_hit) rd_q <= mem[core_addr[OFF_W-1:2]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_v     <= 1'b0;
      pend      <= 1'b0;
      pend_addr <= '0;
    end else begin
      hit_v <= take_hit;
      if (take_miss) begin
        pend      <= 1'b1;
        pend_addr <= core_addr;
      end else if (bus_ack) begin
        pend <= 1'b0;
      end
    end
  end

  assign bus_req    = pend;
  assign bus_addr   = pend_addr;
  assign core_ready = hit_v | (pend & bus_ack);
  assign core_rdata = hit_v ? rd_q : bus_rdata;
endmodule

module fixed_window_iram_chk #(
  parameter int unsigned MEM_BYTES = 4096,
  parameter logic [31:0] WIN_BASE  = 32'h0000_4000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        core_req,
  input logic [31:0] core_addr,
  input logic [31:0] core_rdata,
  input logic        core_ready,
  input logic        bus_req,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_rdata,
  input logic        bus_ack
);
  localparam int unsigned OFF_W = $clog2(MEM_BYTES);
  logic win;
  assign win = core_addr[31:OFF_W] == WIN_BASE[31:OFF_W];

  // R2
  hit_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_req && win && !bus_req |=> core_ready);
  // R5
  hit_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_req && win && !bus_req |=> !bus_req);
  // R4
  miss_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr));
  // R4
  miss_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_req && !win && !bus_req |=> bus_req && bus_addr == $past(core_addr));
  // R6
  ack_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |-> core_ready && core_rdata == bus_rdata);
  // R6
  ack_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req);
  // R7
  wait_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |-> !core_ready);
  // R8
  pending_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> !core_ready || bus_req);
endmodule

bind fixed_window_iram fixed_window_iram_chk #(.MEM_BYTES(MEM_BYTES), .WIN_BASE(WIN_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_addr(core_addr),
  .core_rdata(core_rdata), .core_ready(core_ready), .bus_req(bus_req),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
);

// File: tb/fixed_window_iram_tb.sv
`timescale 1ns/1ps
module fixed_window_iram_tb;
  localparam int unsigned MB   = 4096;
  localparam int unsigned W    = MB / 4;
  localparam logic [31:0] BASE = 32'h0000_4000;

  logic clk = 1'b0;
  logic rst_n;
  logic core_req;
  logic [31:0] core_addr;
  logic [31:0] core_rdata;
  logic core_ready;
  logic bus_req;
  logic [31:0] bus_addr;
  logic [31:0] bus_rdata;
  logic bus_ack;
  logic pl_we;
  logic [9:0] pl_addr;
  logic [31:0] pl_wdata;

  logic [31:0] ref_mem [W];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fixed_window_iram #(.MEM_BYTES(MB), .WIN_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_addr(core_addr),
    .core_rdata(core_rdata), .core_ready(core_ready), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_wdata(pl_wdata)
  );

  function automatic logic [31:0] init_word(int i);
    return (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic bit in_win(logic [31:0] a);
    return (a >= BASE) && (a < BASE + MB);
  endfunction

  function automatic int idx_of(logic [31:0] a);
    return int'((a - BASE) >> 2);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic preload(int i, logic [31:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = 10'(i); pl_wdata = d;
    ref_mem[i] = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic do_hit(logic [31:0] a, string req);
    @(negedge clk);
    core_req = 1'b1; core_addr = a;
    @(negedge clk);
    core_req = 1'b0;
    #1;
    chk({req, " ready"}, 32'(core_ready), 32'd1);
    chk({req, " data"}, core_rdata, ref_mem[idx_of(a)]);
    chk("R5 bus idle on hit", 32'(bus_req), 32'd0);
  endtask

  task automatic do_miss(logic [31:0] a, int waits, bit push, string req);
    logic [31:0] d;
    d = $urandom;
    @(negedge clk);
    core_req = 1'b1; core_addr = a;
    @(negedge clk);
    core_req = push; core_addr = BASE + 32'd8;
    #1;
    chk({req, " R4 bus_req"}, 32'(bus_req), 32'd1);
    chk({req, " R4 bus_addr"}, bus_addr, a);
    chk("R7 stalled", 32'(core_ready), 32'd0);
    for (int k = 0; k < waits; k++) begin
      @(negedge clk);
      #1;
      chk("R4 held", bus_addr, a);
      chk("R7 stalled in wait", 32'(core_ready), 32'd0);
    end
    @(negedge clk);
    bus_ack = 1'b1; bus_rdata = d;
    #1;
    chk("R6 ready on ack", 32'(core_ready), 32'd1);
    chk("R6 data forwarded", core_rdata, d);
    @(negedge clk);
    bus_ack = 1'b0; core_req = 1'b0;
    #1;
    chk("R6 bus_req drops", 32'(bus_req), 32'd0);
    chk("R8 pending fetch ignored", 32'(core_ready), 32'd0);
  endtask

  initial begin
    logic [31:0] a;
    logic [31:0] seq [8];
    void'($urandom(32'd1234));
    rst_n = 1'b0; core_req = 1'b0; core_addr = '0; bus_rdata = '0;
    bus_ack = 1'b0; pl_we = 1'b0; pl_addr = '0; pl_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready in reset", 32'(core_ready), 32'd0);
    chk("R1 bus_req in reset", 32'(bus_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(core_ready), 32'd0);

    for (int i = 0; i < int'(W); i++) preload(i, init_word(i));

    // R10 boundaries
    do_hit(BASE, "R10 first word");
    do_hit(BASE + MB - 4, "R10 last word");
    do_miss(BASE - 4, 0, 1'b0, "R10 below base");
    do_miss(BASE + MB, 2, 1'b1, "R10 past end");

    // R2 preload then fetch
    preload(7, 32'hCAFE_F00D);
    do_hit(BASE + 28, "R2 preloaded word");

    // R9 preload colliding with fetch
    @(negedge clk);
    pl_we = 1'b1; pl_addr = 10'd5; pl_wdata = 32'hDEAD_BEEF;
    core_req = 1'b1; core_addr = BASE + 20;
    @(negedge clk);
    pl_we = 1'b0; core_req = 1'b0;
    #1;
    chk("R9 read during collision", core_rdata, ref_mem[5]);
    do_hit(BASE + 20, "R9 write dropped");

    // R3 back-to-back
    for (int k = 0; k < 8; k++) seq[k] = BASE + 32'(($urandom % W) * 4);
    @(negedge clk);
    core_req = 1'b1; core_addr = seq[0];
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      chk("R3 stream ready", 32'(core_ready), 32'd1);
      chk("R3 stream data", core_rdata, ref_mem[idx_of(seq[k-1])]);
      core_addr = seq[k];
    end
    @(negedge clk);
    core_req = 1'b0;
    chk("R3 stream last", core_rdata, ref_mem[idx_of(seq[7])]);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int r;
      r = int'($urandom % 6);
      if (r == 0) begin
        preload(int'($urandom % W), $urandom);
      end else if (r < 4) begin
        do_hit(BASE + 32'(($urandom % W) * 4), "R2 random hit");
      end else begin
        a = $urandom & 32'hFFFF_FFFC;
        if (in_win(a)) a = a ^ 32'h8000_0000;
        do_miss(a, int'($urandom % 4), 1'($urandom), "random miss");
      end
    end

    done = 1;
    finish_run();
  end
endmodule